// File: doc/BRIEF.md
# Serial register command port

This block decodes the register command that travels in a command slot of a time-division-multiplexed serial frame. A frame sync, sampled on a rising bit clock, marks the start of a command. The 16 bits that follow form a header phase and a data phase. The header carries a read/write flag and a register address. In the data phase the block either collects 8 write bits from the serial input or shifts 8 read bits out on a serial output. That output is meant to drive a tri-state pad: when its enable is low the pad floats.

The block runs on a fast system clock and oversamples the bit clock, frame sync and serial input. It samples input bits on rising bit-clock edges and changes its output and output enable only on falling edges. For a read of an implemented register, the enable turns on one bit period before the first data bit is driven, which hides the time the pad needs to leave high impedance. The small register file holds a device identifier, a control register whose bit 0 enables the audio channel, and scratch registers. The device identifier and the channel enable are also exported to neighbouring logic.

Top module: `regcmd_port`

## Requirements
- R1: After a synchronous active-low reset, `cmd_sdo_oe` and `cmd_sdo` are 0, `dev_id` equals `DEV_ID_RST` and `chan_en` is 0.
- R2: A rising bit-clock edge with `frame_sync` high starts a command. The next 16 rising edges carry, MSB first, the read flag (1 = read), 7 address bits and 8 data bits.
- R3: A write takes effect only after the eighth data bit has been received, and is then visible on `dev_id`/`chan_en` and by readback.
- R4: The address map is: address 0 holds the 8-bit device identifier, address 1 holds control (bit 0 is `chan_en`, bits 7:1 read as 0), and addresses 2 to NREG-1 hold 8-bit scratch values. Addresses NREG and above are unimplemented, and writes to them change nothing.
- R5: For a read of an implemented address, `cmd_sdo_oe` rises on the falling edge that follows the rising edge of the last address bit.
- R6: The read value is driven MSB first on the 8 falling edges that follow the enable, one bit per edge. The first bit comes one bit period after the enable rises.
- R7: `cmd_sdo_oe` falls on the falling edge after the one that drove the last read bit.
- R8: For writes and for reads of unimplemented addresses, `cmd_sdo_oe` stays 0. Whenever `cmd_sdo_oe` is 0, `cmd_sdo` is 0.
- R9: `cmd_sdo` and `cmd_sdo_oe` change only in response to falling bit-clock edges, never on rising ones.
- R10: The data bits of a read command are ignored and do not alter any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, synchronous to clk |
| frame_sync | input | 1 | Frame start marker, sampled on rising bit_clk |
| cmd_sdi | input | 1 | Serial command input, sampled on rising bit_clk |
| cmd_sdo | output | 1 | Serial read data, updated after falling bit_clk |
| cmd_sdo_oe | output | 1 | Pad drive enable for cmd_sdo (0 = high impedance) |
| dev_id | output | DW | Device identifier register contents |
| chan_en | output | 1 | Audio channel enable (control register bit 0) |

## Verification
The bench builds the block with NREG = 5 and a non-zero device identifier reset value of 8'hA5. This makes the reset value distinguishable from a cleared register. It also puts both the last implemented address (4) and the first unimplemented one (5) in range, next to address 127. Each frame is 20 bit periods long, so the tail of a read, which extends past the 16-bit command field, is observed in full. The outputs are sampled before every rising edge and again before every falling edge, which exposes any change tied to the wrong edge.

// File: rtl/regcmd_pkg.sv
// Package: shared sizes for the serial register command port.
// Assumes an 8-bit register width and a 7-bit register address by default.
package regcmd_pkg;
    localparam int CMD_AW  = 7;   // register address bits in a command
    localparam int CMD_DW  = 8;   // register data bits in a command
    localparam int CMD_NREG = 4;  // default count of implemented registers
    localparam int ADDR_DEVID = 0;
    localparam int ADDR_CTRL  = 1;
endpackage

// File: rtl/regcmd_edge.sv
// Module: regcmd_edge
// Samples the serial bit clock, frame sync and data input into the system
// clock domain and produces one-cycle rise/fall pulses of the bit clock.
// Assumes the inputs are already synchronous to clk and that clk runs at
// least four times faster than the bit clock.
module regcmd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic fs_in,
    input  logic di_in,
    output logic bck_rise,
    output logic bck_fall,
    output logic fs_s,
    output logic di_s
);
    logic bck_s;
    logic bck_p;

    // Register the serial inputs together so the data stays aligned with the edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_s <= 1'b0;
            bck_p <= 1'b0;
            fs_s  <= 1'b0;
            di_s  <= 1'b0;
        end else begin
            bck_s <= bck_in;
            bck_p <= bck_s;
            fs_s  <= fs_in;
            di_s  <= di_in;
        end
    end

    // Edge pulses from the current and previous sampled bit clock.
    always_comb begin
        bck_rise = bck_s & ~bck_p;
        bck_fall = ~bck_s & bck_p;
    end
endmodule

// File: rtl/regcmd_seq.sv
// Module: regcmd_seq
// Counts command bits after a frame sync and shifts them in MSB first.
// Flags the moment the header (read flag + address) is complete, and emits
// a one-cycle write strobe after the last data bit of a write command.
// Assumes frames are longer than the command field.
module regcmd_seq #(
    parameter int AW = regcmd_pkg::CMD_AW,
    parameter int DW = regcmd_pkg::CMD_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bck_rise,
    input  logic          fs_s,
    input  logic          di_s,
    output logic          hdr_ready,
    output logic          hdr_rd,
    output logic [AW-1:0] hdr_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int FRAME = 1 + AW + DW;
    localparam int CW    = $clog2(FRAME + 1);
    localparam int SW    = FRAME - 1;

    logic [CW-1:0] cnt;
    logic [SW-1:0] sh;
    logic          last_bit;

    // The final command bit arrives on this rising edge.
    always_comb last_bit = bck_rise && !fs_s && (cnt == CW'(FRAME - 1));

    // Bit counter and input shift register; the counter parks at FRAME when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(FRAME);
            sh  <= '0;
        end else if (bck_rise) begin
            if (fs_s) begin
                cnt <= '0;
            end else if (cnt != CW'(FRAME)) begin
                sh  <= {sh[SW-2:0], di_s};
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Write strobe with address and data, taken from the shift register before it moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= last_bit && !sh[SW-1];
            if (last_bit) begin
                wr_addr <= sh[SW-2 -: AW];
                wr_data <= {sh[DW-2:0], di_s};
            end
        end
    end

    // Header decode while the counter sits just past the last address bit.
    always_comb begin
        hdr_ready = (cnt == CW'(1 + AW));
        hdr_rd    = sh[AW];
        hdr_addr  = sh[AW-1:0];
    end
endmodule

// File: rtl/regcmd_regfile.sv
// Module: regcmd_regfile
// Holds the device identifier, the control register and scratch registers.
// Provides a combinational read port and exports the identifier and channel
// enable. Assumes 2 <= NREG <= 2**AW.
module regcmd_regfile #(
    parameter int          AW         = regcmd_pkg::CMD_AW,
    parameter int          DW         = regcmd_pkg::CMD_DW,
    parameter int          NREG       = regcmd_pkg::CMD_NREG,
    parameter logic [DW-1:0] DEV_ID_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [DW-1:0] dev_id,
    output logic          chan_en
);
    localparam logic [DW-1:0] CTRL_MASK = DW'(1);

    logic [NREG-1:0][DW-1:0] rvec;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        logic          hit;
        assign hit = wr_en && (wr_addr == AW'(g));
        if (g == regcmd_pkg::ADDR_DEVID) begin : g_devid
            // Device identifier: full-width, resets to the configured value.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= DEV_ID_RST;
                else if (hit) q <= wr_data;
            end
        end else if (g == regcmd_pkg::ADDR_CTRL) begin : g_ctrl
            // Control register: only the channel enable bit is stored.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wr_data & CTRL_MASK;
            end
        end else begin : g_scratch
            // Scratch register: full-width, resets to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wr_data;
            end
        end
        assign rvec[g] = q;
    end

    // Read port: selected register, or zero for an unimplemented address.
    always_comb begin
        rd_data  = '0;
        rd_valid = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data  = rvec[i];
                rd_valid = 1'b1;
            end
        end
    end

    // Exported register contents.
    always_comb begin
        dev_id  = rvec[regcmd_pkg::ADDR_DEVID];
        chan_en = rvec[regcmd_pkg::ADDR_CTRL][0];
    end
endmodule

// File: rtl/regcmd_dout.sv
// Module: regcmd_dout
// Drives the serial read output and its pad enable on falling bit-clock
// edges. The enable turns on at the falling edge where a valid read starts,
// and data follows MSB first from the next falling edge. The enable turns off
// one falling edge after the last bit. Assumes rd_start is stable across a fall.
module regcmd_dout #(
    parameter int DW = regcmd_pkg::CMD_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bck_fall,
    input  logic          rd_start,
    input  logic [DW-1:0] rd_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int NW = $clog2(DW + 1);

    logic [DW-1:0] sh;
    logic [NW-1:0] nsent;

    // Output shifter: start, shift one bit per falling edge, then release the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            sh     <= '0;
            nsent  <= '0;
        end else if (bck_fall) begin
            if (sdo_oe) begin
                if (nsent == NW'(DW)) begin
                    sdo_oe <= 1'b0;
                    sdo    <= 1'b0;
                end else begin
                    sdo   <= sh[DW-1];
                    sh    <= {sh[DW-2:0], 1'b0};
                    nsent <= nsent + 1'b1;
                end
            end else if (rd_start) begin
                sdo_oe <= 1'b1;
                sdo    <= 1'b0;
                sh     <= rd_data;
                nsent  <= '0;
            end
        end
    end
endmodule

// File: rtl/regcmd_port.sv
// Module: regcmd_port (top)
// Serial register command port: decodes a read/write command from a TDM
// command slot, updates or reads a small register file, and drives read
// data on a tri-stateable output. Assumes clk >= 4x bit_clk, and frames of
// at least 1 + AW + DW + 2 bit periods.
module regcmd_port #(
    parameter int            NREG       = regcmd_pkg::CMD_NREG,
    parameter int            AW         = regcmd_pkg::CMD_AW,
    parameter int            DW         = regcmd_pkg::CMD_DW,
    parameter logic [DW-1:0] DEV_ID_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_clk,
    input  logic          frame_sync,
    input  logic          cmd_sdi,
    output logic          cmd_sdo,
    output logic          cmd_sdo_oe,
    output logic [DW-1:0] dev_id,
    output logic          chan_en
);
    logic          bck_rise;
    logic          bck_fall;
    logic          fs_s;
    logic          di_s;
    logic          hdr_ready;
    logic          hdr_rd;
    logic [AW-1:0] hdr_addr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_start;

    regcmd_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_in   (bit_clk),
        .fs_in    (frame_sync),
        .di_in    (cmd_sdi),
        .bck_rise (bck_rise),
        .bck_fall (bck_fall),
        .fs_s     (fs_s),
        .di_s     (di_s)
    );

    regcmd_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck_rise  (bck_rise),
        .fs_s      (fs_s),
        .di_s      (di_s),
        .hdr_ready (hdr_ready),
        .hdr_rd    (hdr_rd),
        .hdr_addr  (hdr_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    regcmd_regfile #(.AW(AW), .DW(DW), .NREG(NREG), .DEV_ID_RST(DEV_ID_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (hdr_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .dev_id   (dev_id),
        .chan_en  (chan_en)
    );

    // A read starts only for a complete header that names an implemented register.
    always_comb rd_start = hdr_ready && hdr_rd && rd_valid;

    regcmd_dout #(.DW(DW)) u_dout (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_fall (bck_fall),
        .rd_start (rd_start),
        .rd_data  (rd_data),
        .sdo      (cmd_sdo),
        .sdo_oe   (cmd_sdo_oe)
    );
endmodule

// File: rtl/regcmd_port_chk.sv
// Module: regcmd_port_chk
// Checker bound into regcmd_port: output edge alignment, enable qualification,
// quiet pad and ignored writes to unimplemented addresses.
module regcmd_port_chk #(
    parameter int NREG = regcmd_pkg::CMD_NREG,
    parameter int AW   = regcmd_pkg::CMD_AW,
    parameter int DW   = regcmd_pkg::CMD_DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bck_rise,
    input logic          bck_fall,
    input logic          rd_start,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          cmd_sdo,
    input logic          cmd_sdo_oe,
    input logic [DW-1:0] dev_id,
    input logic          chan_en
);
    // R9
    sdo_oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_sdo_oe) |-> $past(bck_fall));

    // R9
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_sdo) |-> $past(bck_fall));

    // R9
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bck_rise, bck_fall}));

    // R5
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_sdo_oe) |-> $past(rd_start));

    // R8
    quiet_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_sdo_oe |-> !cmd_sdo);

    // R4
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= AW'(NREG))) |=> ($stable(dev_id) && $stable(chan_en)));
endmodule

bind regcmd_port regcmd_port_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bck_rise   (bck_rise),
    .bck_fall   (bck_fall),
    .rd_start   (rd_start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cmd_sdo    (cmd_sdo),
    .cmd_sdo_oe (cmd_sdo_oe),
    .dev_id     (dev_id),
    .chan_en    (chan_en)
);

// File: tb/test_regcmd_port.sv
`timescale 1ns/1ps
// Bench for regcmd_port: a behavioural register model predicts the pad
// enable and data for every bit period of every frame.
module test_regcmd_port;
    localparam int NREG = 5;
    localparam logic [7:0] DEVRST = 8'hA5;
    localparam int FRAME_PERIODS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_clk = 1'b0;
    logic       frame_sync = 1'b0;
    logic       cmd_sdi = 1'b0;
    logic       cmd_sdo;
    logic       cmd_sdo_oe;
    logic [7:0] dev_id;
    logic       chan_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int mregs[NREG];

    always #2.5 clk = ~clk;

    regcmd_port #(.NREG(NREG), .AW(7), .DW(8), .DEV_ID_RST(DEVRST)) i_regcmd_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_clk    (bit_clk),
        .frame_sync (frame_sync),
        .cmd_sdi    (cmd_sdi),
        .cmd_sdo    (cmd_sdo),
        .cmd_sdo_oe (cmd_sdo_oe),
        .dev_id     (dev_id),
        .chan_en    (chan_en)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Send one 20-period frame and compare the pad outputs in every period.
    task automatic send_frame(input bit rd, input int addr, input int data);
        logic [15:0] w;
        bit          valid;
        bit          rdv;
        int          e;
        w     = {rd, addr[6:0], data[7:0]};
        valid = addr < NREG;
        rdv   = rd && valid;
        e     = valid ? mregs[addr] : 0;
        for (int p = 0; p < FRAME_PERIODS; p++) begin
            bit    eo;
            bit    ed;
            string ro;
            string rdq;
            eo = rdv && (p >= 9) && (p <= 17);
            ed = (rdv && (p >= 10) && (p <= 17)) ? e[7 - (p - 10)] : 1'b0;
            if (!rdv)        ro = "R8";
            else if (p == 9) ro = "R5";
            else if (p >= 17) ro = "R7";
            else             ro = "R6";
            rdq = rdv ? "R6" : "R8";
            // falling edge: host drives sync and data
            @(negedge clk);
            bit_clk    = 1'b0;
            frame_sync = (p == 0);
            cmd_sdi    = (p >= 1 && p <= 16) ? w[16 - p] : 1'b0;
            repeat (4) @(negedge clk);
            chk(ro,  $sformatf("oe a%0d p%0d", addr, p), int'(cmd_sdo_oe), int'(eo));
            chk(rdq, $sformatf("sdo a%0d p%0d", addr, p), int'(cmd_sdo), int'(ed));
            bit_clk = 1'b1;
            repeat (4) @(negedge clk);
            // R9: no change across the rising edge
            chk("R9", $sformatf("oe hold p%0d", p), int'(cmd_sdo_oe), int'(eo));
            chk("R9", $sformatf("sdo hold p%0d", p), int'(cmd_sdo), int'(ed));
        end
        // R3/R4: model update only for a write to an implemented address
        if (!rd && valid) mregs[addr] = (addr == 1) ? (data & 1) : (data & 8'hFF);
        chk("R3", "dev_id port", int'(dev_id), mregs[0]);
        chk("R3", "chan_en port", int'(chan_en), mregs[1] & 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) mregs[i] = 0;
        mregs[0] = DEVRST;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "oe after reset", int'(cmd_sdo_oe), 0);
        chk("R1", "sdo after reset", int'(cmd_sdo), 0);
        chk("R1", "dev_id after reset", int'(dev_id), DEVRST);
        chk("R1", "chan_en after reset", int'(chan_en), 0);

        // R2/R6: read reset identifier, then write and read back patterns
        send_frame(1'b1, 0, 8'h00);
        send_frame(1'b0, 0, 8'h3C);
        send_frame(1'b1, 0, 8'h00);
        // R4: control keeps only bit 0
        send_frame(1'b0, 1, 8'hFF);
        send_frame(1'b1, 1, 8'h00);
        send_frame(1'b0, 2, 8'h96);
        send_frame(1'b0, 4, 8'h81);
        send_frame(1'b1, 2, 8'h00);
        send_frame(1'b1, 4, 8'h00);
        // R4/R8: unimplemented addresses
        send_frame(1'b0, 5, 8'h77);
        send_frame(1'b0, 127, 8'hEE);
        for (int a = 0; a < NREG; a++) send_frame(1'b1, a, 8'h00);
        send_frame(1'b1, 5, 8'h00);
        send_frame(1'b1, 127, 8'h00);
        // R10: data bits in a read are ignored
        send_frame(1'b1, 0, 8'hFF);
        chk("R10", "dev_id after junk read", int'(dev_id), 8'h3C);
        send_frame(1'b1, 3, 8'h5A);
        send_frame(1'b1, 3, 8'h00);
        chk("R10", "scratch3 unchanged", mregs[3], 0);
        // R3: clear channel enable, alternate patterns
        send_frame(1'b0, 1, 8'h00);
        send_frame(1'b0, 3, 8'h5A);
        send_frame(1'b1, 3, 8'h00);
        send_frame(1'b0, 3, 8'hA5);
        send_frame(1'b1, 3, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule